// File: doc/BRIEF.md
# Microcode ROM Test Readout Sequencer

This block sits between the control-store address register and the two control-store ROMs (a micro ROM and a nano ROM) and gives a tester direct access to every stored word. In functional mode the address register follows the address offered by the microsequencer, and the observation bus stays quiet. When test mode is raised, the external data pins supply both the next ROM address and the number of a 32-bit window over the joined ROM outputs. The chosen window is carried through an internal register stage and out onto the observation (address) bus.

The joined ROM word is 110 bits wide, which is more than the 32-bit observation bus can carry. A full dump is therefore made in four passes over all 2048 addresses, one window number per pass. Each read takes a two-clock pair. In the first clock the address and window number are taken from the pins. In the second clock the window is shown with a valid strobe. One 32-bit window therefore leaves the chip every two clocks.

Top module: `ucrom_test_readout`

## Requirements
- R1: In test mode, the first clock edge of each pair loads `rom_addr` from `data_pin[10:0]`.
- R2: At the load edge, `data_pin[12:11]` picks the window. The joined word is `{nano_q, micro_q}`, with `micro_q` in the low 42 bits. Window 0 shows bits [31:0], window 1 shows [63:32], window 2 shows [95:64] and window 3 shows [109:96].
- R3: Window 3 is padded with zeros, so `obs_bus[31:14]` is 0 whenever window 3 is shown.
- R4: `obs_valid` is high for exactly one cycle, after the second edge of each pair. It is low after the load edge, so a new window appears every two clocks.
- R5: Pin changes between the load edge and the show edge are ignored. `rom_addr` and the shown window keep the loaded values.
- R6: Outside test mode, `rom_addr` equals the `seq_addr` value sampled at the previous edge. In test mode, `seq_addr` has no effect on `rom_addr`.
- R7: One edge after `test_en` goes low, `obs_oe` and `obs_valid` are 0 and `obs_bus` is 0. This holds even when a pair is left unfinished.
- R8: While reset is held, `rom_addr`, `obs_bus`, `obs_valid` and `obs_oe` are all 0.
- R9: Every one of the 2048 addresses can be read under every one of the four windows.
- R10: The first edge with `test_en` high is always a load edge, including on re-entry to test mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en | input | 1 | Test-mode enable |
| data_pin | input | 13 | Forced address [10:0] and window number [12:11] |
| seq_addr | input | 11 | Next address from the functional microsequencer |
| rom_addr | output | 11 | Registered address to both ROMs |
| micro_q | input | 42 | Micro ROM read data |
| nano_q | input | 68 | Nano ROM read data |
| obs_bus | output | 32 | Observation bus carrying the selected window |
| obs_valid | output | 1 | Window on `obs_bus` is valid this cycle |
| obs_oe | output | 1 | Observation bus drive enable (test mode) |

## Verification
The phase bit has no port of its own, but a wrong value shows within one pair. If it is wrong, `obs_valid` rises after the load edge instead of the show edge, or `rom_addr` moves to garbage pins placed between the two edges. A wrong window number or bit order gives a mismatched `obs_bus` word on the very next show cycle. The four-pass sweep over all addresses exposes any address line or window slice that is stuck or swapped. A stale address source in functional mode shows on `rom_addr` one edge after `seq_addr` changes.

// File: rtl/ucrom_test_pkg.sv
package ucrom_test_pkg;
  typedef enum logic {
    PH_LOAD = 1'b0,
    PH_SHOW = 1'b1
  } phase_e;
endpackage

// File: rtl/ucrom_rst_sync.sv
module ucrom_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;

  // Asserts at once, releases after two edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/ucrom_readout_ctrl.sv
module ucrom_readout_ctrl
  import ucrom_test_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic test_en,
  output logic load_en,
  output logic capture_en,
  output logic valid_q,
  output logic oe_q
);
  phase_e phase_q, phase_d;
  logic   valid_d, oe_d;

  always_comb begin
    load_en    = test_en && (phase_q == PH_LOAD);
    capture_en = test_en && (phase_q == PH_SHOW);
    if (!test_en)                phase_d = PH_LOAD;
    else if (phase_q == PH_LOAD) phase_d = PH_SHOW;
    else                         phase_d = PH_LOAD;
    valid_d = capture_en;
    oe_d    = test_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_LOAD;
      valid_q <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      valid_q <= valid_d;
      oe_q    <= oe_d;
    end
  end
endmodule

// File: rtl/ucrom_nma_reg.sv
module ucrom_nma_reg #(
  parameter int ADDR_W = 11,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_en,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] pin_addr,
  input  logic [SEL_W-1:0]  pin_sel,
  input  logic [ADDR_W-1:0] seq_addr,
  output logic [ADDR_W-1:0] nma_q,
  output logic [SEL_W-1:0]  sel_q
);
  logic [ADDR_W-1:0] nma_d;
  logic [SEL_W-1:0]  sel_d;

  always_comb begin
    nma_d = nma_q;
    sel_d = sel_q;
    if (!test_en) begin
      nma_d = seq_addr;
      sel_d = '0;
    end else if (load_en) begin
      nma_d = pin_addr;
      sel_d = pin_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nma_q <= '0;
      sel_q <= '0;
    end else begin
      nma_q <= nma_d;
      sel_q <= sel_d;
    end
  end
endmodule

// File: rtl/ucrom_slice_mux.sv
module ucrom_slice_mux #(
  parameter int WORD_W = 110,
  parameter int OBS_W  = 32,
  parameter int SEL_W  = 2
) (
  input  logic [WORD_W-1:0] word,
  input  logic [SEL_W-1:0]  sel,
  output logic [OBS_W-1:0]  slice
);
  localparam int NUM_SLICES = (WORD_W + OBS_W - 1) / OBS_W;
  localparam int PADDED_W   = NUM_SLICES * OBS_W;

  logic [PADDED_W-1:0] padded;
  logic [OBS_W-1:0]    slc [NUM_SLICES];

  always_comb begin
    padded               = '0;
    padded[WORD_W-1:0]   = word;
  end

  for (genvar g = 0; g < NUM_SLICES; g++) begin : g_slice
    assign slc[g] = padded[g*OBS_W +: OBS_W];
  end

  always_comb begin
    slice = '0;
    for (int i = 0; i < NUM_SLICES; i++) begin
      if (int'(sel) == i) slice = slc[i];
    end
  end
endmodule

// File: rtl/ucrom_test_readout.sv
module ucrom_test_readout #(
  parameter int ADDR_W  = 11,
  parameter int SEL_W   = 2,
  parameter int MICRO_W = 42,
  parameter int NANO_W  = 68,
  parameter int OBS_W   = 32,
  localparam int PIN_W  = ADDR_W + SEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               test_en,
  input  logic [PIN_W-1:0]   data_pin,
  input  logic [ADDR_W-1:0]  seq_addr,
  output logic [ADDR_W-1:0]  rom_addr,
  input  logic [MICRO_W-1:0] micro_q,
  input  logic [NANO_W-1:0]  nano_q,
  output logic [OBS_W-1:0]   obs_bus,
  output logic               obs_valid,
  output logic               obs_oe
);
  localparam int WORD_W = MICRO_W + NANO_W;

  logic              rst_n_sync;
  logic              load_en, capture_en;
  logic [SEL_W-1:0]  sel_q;
  logic [OBS_W-1:0]  slice, obs_q;
  logic [WORD_W-1:0] rom_word;

  ucrom_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  ucrom_readout_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .test_en    (test_en),
    .load_en    (load_en),
    .capture_en (capture_en),
    .valid_q    (obs_valid),
    .oe_q       (obs_oe)
  );

  ucrom_nma_reg #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_nma (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .test_en  (test_en),
    .load_en  (load_en),
    .pin_addr (data_pin[ADDR_W-1:0]),
    .pin_sel  (data_pin[PIN_W-1:ADDR_W]),
    .seq_addr (seq_addr),
    .nma_q    (rom_addr),
    .sel_q    (sel_q)
  );

  assign rom_word = {nano_q, micro_q};

  ucrom_slice_mux #(.WORD_W(WORD_W), .OBS_W(OBS_W), .SEL_W(SEL_W)) u_mux (
    .word  (rom_word),
    .sel   (sel_q),
    .slice (slice)
  );

  // Internal bus stage toward the observation bus.
  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      obs_q <= '0;
    end else if (capture_en) begin
      obs_q <= slice;
    end
  end

  assign obs_bus = obs_valid ? obs_q : '0;
endmodule

// File: rtl/ucrom_test_readout_chk.sv
module ucrom_test_readout_chk #(
  parameter int ADDR_W = 11,
  parameter int OBS_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              test_en,
  input logic [ADDR_W-1:0] seq_addr,
  input logic [ADDR_W-1:0] rom_addr,
  input logic [OBS_W-1:0]  obs_bus,
  input logic              obs_valid,
  input logic              obs_oe
);
  AST_FUNC_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |=> rom_addr == $past(seq_addr)); // R6

  AST_VALID_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    obs_valid |=> !obs_valid); // R4

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    obs_valid |-> $stable(rom_addr)); // R5

  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !obs_oe |-> (!obs_valid && obs_bus == '0)); // R7

  AST_OE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |=> !obs_oe); // R7
endmodule

bind ucrom_test_readout ucrom_test_readout_chk #(.ADDR_W(ADDR_W), .OBS_W(OBS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .test_en   (test_en),
  .seq_addr  (seq_addr),
  .rom_addr  (rom_addr),
  .obs_bus   (obs_bus),
  .obs_valid (obs_valid),
  .obs_oe    (obs_oe)
);

// File: tb/ucrom_test_readout_test.sv
`timescale 1ns/1ps
module ucrom_test_readout_test;
  localparam int AW = 11;
  localparam int SW = 2;
  localparam int MW = 42;
  localparam int NW = 68;
  localparam int OW = 32;
  localparam int WW = MW + NW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          test_en;
  logic [AW+SW-1:0] data_pin;
  logic [AW-1:0] seq_addr;
  logic [AW-1:0] rom_addr;
  logic [MW-1:0] micro_q;
  logic [NW-1:0] nano_q;
  logic [OW-1:0] obs_bus;
  logic          obs_valid, obs_oe;
  logic [WW-1:0] model_word;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [WW-1:0] rom_word(input logic [AW-1:0] a);
    logic [127:0] w;
    logic [31:0]  h;
    for (int k = 0; k < 4; k++) begin
      h = ({21'd0, a} + 32'd1) * 32'h9E3779B1;
      h = h ^ (32'h85EBCA6B * (k + 3));
      h = {h[18:0], h[31:19]} ^ {21'd0, a};
      w[k*32 +: 32] = h;
    end
    return w[WW-1:0];
  endfunction

  function automatic logic [OW-1:0] exp_slice(input logic [AW-1:0] a, input logic [SW-1:0] s);
    logic [127:0] p;
    p = '0;
    p[WW-1:0] = rom_word(a);
    return p[int'(s)*OW +: OW];
  endfunction

  assign model_word = rom_word(rom_addr);
  assign micro_q    = model_word[MW-1:0];
  assign nano_q     = model_word[WW-1:MW];

  ucrom_test_readout uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_en   (test_en),
    .data_pin  (data_pin),
    .seq_addr  (seq_addr),
    .rom_addr  (rom_addr),
    .micro_q   (micro_q),
    .nano_q    (nano_q),
    .obs_bus   (obs_bus),
    .obs_valid (obs_valid),
    .obs_oe    (obs_oe)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One two-clock readout; entered and left at a falling edge.
  task automatic read_pair(input logic [AW-1:0] a, input logic [SW-1:0] s, input string tag);
    logic [AW+SW-1:0] junk;
    logic [OW-1:0] e;
    test_en  = 1'b1;
    data_pin = {s, a};
    seq_addr = AW'($urandom);
    @(negedge clk);
    check(rom_addr == a, {tag, " R1 addr"}, 64'(rom_addr), 64'(a));
    check(!obs_valid && obs_oe, {tag, " R4 valid low after load"}, {62'd0, obs_valid, obs_oe}, 64'd1);
    junk     = (AW+SW)'($urandom);
    data_pin = junk;
    seq_addr = AW'($urandom);
    @(negedge clk);
    e = exp_slice(a, s);
    check(obs_valid, {tag, " R4 valid"}, 64'(obs_valid), 64'd1);
    check(obs_bus == e, {tag, " R2 slice"}, 64'(obs_bus), 64'(e));
    check(rom_addr == a, {tag, " R5 pins ignored"}, 64'(rom_addr), 64'(a));
    if (s == 2'd3)
      check(obs_bus[31:14] == '0, {tag, " R3 pad"}, 64'(obs_bus[31:14]), 64'd0);
  endtask

  initial begin
    int seed;
    logic [AW-1:0] prev;
    seed = 11;
    void'($urandom(seed));
    rst_n    = 1'b0;
    test_en  = 1'b0;
    data_pin = '0;
    seq_addr = 11'h2A5;
    repeat (3) @(negedge clk);
    // R8 reset state
    check(rom_addr == '0 && obs_bus == '0 && !obs_valid && !obs_oe, "R8 reset",
          {obs_bus, 20'd0, rom_addr, obs_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6 / R7 functional mode
    for (int i = 0; i < 20; i++) begin
      prev     = AW'($urandom);
      seq_addr = prev;
      data_pin = (AW+SW)'($urandom);
      @(negedge clk);
      check(rom_addr == prev, "R6 follows seq_addr", 64'(rom_addr), 64'(prev));
      check(!obs_oe && !obs_valid && obs_bus == '0, "R7 quiet", {31'd0, obs_bus, obs_oe}, 64'd0);
    end

    // R10 first test edge is a load edge
    read_pair(11'h7FF, 2'd0, "R10");

    // R9 exhaustive four-pass sweep
    for (int s = 0; s < 4; s++)
      for (int a = 0; a < (1 << AW); a++)
        read_pair(AW'(a), SW'(s), "R9");

    // random mix
    for (int i = 0; i < 300; i++)
      read_pair(AW'($urandom), SW'($urandom), "rand");

    // R7 leave test mode
    prev     = 11'h155;
    test_en  = 1'b0;
    seq_addr = prev;
    @(negedge clk);
    check(!obs_oe && !obs_valid && obs_bus == '0, "R7 exit", {31'd0, obs_bus, obs_oe}, 64'd0);
    check(rom_addr == prev, "R6 after exit", 64'(rom_addr), 64'(prev));

    // R10 re-entry
    read_pair(11'h001, 2'd3, "R10 reentry");

    // R7 abort between load and show
    test_en  = 1'b1;
    data_pin = {2'd1, 11'h300};
    @(negedge clk);
    test_en = 1'b0;
    @(negedge clk);
    check(!obs_valid && obs_bus == '0 && !obs_oe, "R7 abort", {31'd0, obs_bus, obs_valid}, 64'd0);
    read_pair(11'h0F0, 2'd2, "R10 after abort");
    test_en = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule